// File: doc/BRIEF.md
# Dual-Reload Three-Mode Timer

This block is a down-counting timer with two companion registers, A and B, and two pins. TA can be an output or an input; TB is always an input. A three-bit mode field picks one of three uses. In the waveform mode, the counter is reloaded from A and B in turn, with no software help, and TA can toggle on every reload. In the event-count mode, the counter steps on edges seen on TA. In the capture mode, edges on TA and TB copy the free-running counter into A and B.

Two pending flags, their enables and a run bit produce a single interrupt line. In capture mode the run bit becomes the underflow pending flag. The register write strobes and the flag-clear strobes stand in for the processor bus, which lies outside this block.

Top module: `dual_reload_timer`

## Requirements
- R1: After synchronous reset, the counter, A, B, both pending flags, the run bit, the TA output level and the interrupt are all 0.
- R2: In waveform mode (mode 000 or 001), the counter decrements once per cycle with tick_i high, but only while the run bit is 1. run_set_i sets the run bit and takes priority over run_clr_i, which clears it.
- R3: In waveform mode, a decrement from 0 is an underflow and reloads the counter. The first reload after a start comes from A, and later reloads alternate B, A, B, and so on. Any change of mode_i, or a cycle with the run bit at 0, makes the next reload come from A again.
- R4: Mode 001 inverts ta_o on every underflow and drives ta_oe_o high. In every other mode ta_oe_o is low and ta_o holds its level.
- R5: A reload from A sets pend_a_o and a reload from B sets pend_b_o. irq_o is (pend_a_o & en_a_i) | (pend_b_o & en_b_i), OR'd in capture mode with (run_o & en_a_i).
- R6: A pending flag holds until a clear strobe (clr_pend_a_i or clr_pend_b_i) removes it. When a set event and a clear fall in the same cycle, the flag ends up set.
- R7: In event mode (010 rising edge, 011 falling edge), the counter decrements on the selected TA edge while the run bit is 1, and tick_i has no effect. TA passes through two synchronising flops and an edge register, so a pin change takes effect three clock edges later. An underflow reloads the counter from A and sets pend_a_o.
- R8: In event mode, a rising edge on TB sets pend_b_o.
- R9: In capture mode (mode 1xy; y=1 means falling-edge TA, x=1 means falling-edge TB, otherwise rising), the counter decrements on every tick whatever the run bit holds, and wraps from 0 to all ones. A selected TA edge copies the counter into A and sets pend_a_o. A selected TB edge copies it into B and sets pend_b_o. An edge of the other polarity changes nothing.
- R10: In capture mode, an underflow sets the run bit, which then serves as the underflow pending flag. run_clr_i clears it.
- R11: A write to the counter through we_timer_i takes priority over a decrement or a reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Instruction-rate count enable |
| mode_i | input | 3 | Mode field, encoded as in R2, R4, R7, R9 |
| wdata_i | input | 16 | Write data for counter, A, B |
| we_timer_i | input | 1 | Write wdata_i into the counter |
| we_a_i | input | 1 | Write wdata_i into A |
| we_b_i | input | 1 | Write wdata_i into B |
| run_set_i | input | 1 | Set the run bit |
| run_clr_i | input | 1 | Clear the run bit |
| clr_pend_a_i | input | 1 | Clear pending flag A |
| clr_pend_b_i | input | 1 | Clear pending flag B |
| en_a_i | input | 1 | Interrupt enable for A and capture underflow |
| en_b_i | input | 1 | Interrupt enable for B |
| ta_i | input | 1 | TA pin input |
| tb_i | input | 1 | TB pin input |
| timer_o | output | 16 | Counter value |
| reg_a_o | output | 16 | Register A |
| reg_b_o | output | 16 | Register B |
| run_o | output | 1 | Run bit / capture underflow flag |
| pend_a_o | output | 1 | Pending flag A |
| pend_b_o | output | 1 | Pending flag B |
| ta_o | output | 1 | TA output level |
| ta_oe_o | output | 1 | TA output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Two collisions matter most. The first is a reload that sets a pending flag in the same cycle as the software clear of that flag. The second is a counter write that lands on a cycle where a decrement or reload is due. A seeded random run in waveform mode drives ticks, clear strobes, run starts and stops, and enable changes independently. A bench model of the alternating reload checks the counter, the flags, TA and the interrupt every cycle. Directed cases then force each collision exactly: an underflow together with a clear, and a write together with a tick. The expected outcome is a flag that stays set and a counter that holds the written value.

// File: rtl/drt_pkg.sv
package drt_pkg;

    typedef enum logic [1:0] {
        KIND_PWM = 2'd0,
        KIND_EVT = 2'd1,
        KIND_CAP = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  pwm_toggle;
        logic  evt_fall;
        logic  cap_a_fall;
        logic  cap_b_fall;
    } mode_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    typedef struct packed {
        logic dec;
        logic uf;
        logic rld_a;
        logic rld_b;
        logic cap_a;
        logic cap_b;
        logic tb_evt;
    } tmr_evt_t;

    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t c;
        c = '0;
        if (m[2]) begin
            c.kind       = KIND_CAP;
            c.cap_a_fall = m[0];
            c.cap_b_fall = m[1];
        end else if (m[1]) begin
            c.kind     = KIND_EVT;
            c.evt_fall = m[0];
        end else begin
            c.kind       = KIND_PWM;
            c.pwm_toggle = m[0];
        end
        return c;
    endfunction

endpackage

// File: rtl/drt_sync_edge.sv
module drt_sync_edge
    import drt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      d_i,
    output pin_edge_t edg_o
);
    logic [STAGES-1:0] sr_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sr_q   <= {sr_q[STAGES-2:0], d_i};
            last_q <= sr_q[STAGES-1];
        end
    end

    assign edg_o.rise = sr_q[STAGES-1] & ~last_q;
    assign edg_o.fall = ~sr_q[STAGES-1] & last_q;

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(edg_o.rise && edg_o.fall)); // R7
endmodule

// File: rtl/drt_seq.sv
module drt_seq
    import drt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  kind_e     kind_i,
    input  logic      evt_fall_i,
    input  logic      cap_a_fall_i,
    input  logic      cap_b_fall_i,
    input  logic      mode_chg_i,
    input  logic      tick_i,
    input  pin_edge_t ta_e_i,
    input  pin_edge_t tb_e_i,
    input  logic      timer_zero_i,
    input  logic      run_set_i,
    input  logic      run_clr_i,
    output tmr_evt_t  ev_o,
    output logic      run_o
);
    logic run_q;
    logic alt_q;
    logic ta_cnt_edge;
    logic ta_cap_edge;
    logic tb_cap_edge;

    assign ta_cnt_edge = evt_fall_i   ? ta_e_i.fall : ta_e_i.rise;
    assign ta_cap_edge = cap_a_fall_i ? ta_e_i.fall : ta_e_i.rise;
    assign tb_cap_edge = cap_b_fall_i ? tb_e_i.fall : tb_e_i.rise;

    always_comb begin
        ev_o = '0;
        unique case (kind_i)
            KIND_PWM: ev_o.dec = run_q & tick_i;
            KIND_EVT: begin
                ev_o.dec    = run_q & ta_cnt_edge;
                ev_o.tb_evt = tb_e_i.rise;
            end
            KIND_CAP: begin
                ev_o.dec   = tick_i;
                ev_o.cap_a = ta_cap_edge;
                ev_o.cap_b = tb_cap_edge;
            end
            default: ev_o = '0;
        endcase
        ev_o.uf    = ev_o.dec & timer_zero_i;
        ev_o.rld_a = ev_o.uf & ((kind_i == KIND_EVT) | ((kind_i == KIND_PWM) & ~alt_q));
        ev_o.rld_b = ev_o.uf & (kind_i == KIND_PWM) & alt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            alt_q <= 1'b0;
        end else begin
            if (((kind_i == KIND_CAP) && ev_o.uf) || run_set_i)
                run_q <= 1'b1;
            else if (run_clr_i)
                run_q <= 1'b0;

            if (mode_chg_i || (kind_i != KIND_PWM) || !run_q)
                alt_q <= 1'b0;
            else if (ev_o.uf)
                alt_q <= ~alt_q;
        end
    end

    assign run_o = run_q;

    AST_ALT_FLIP: assert property (@(posedge clk) disable iff (rst)
        (kind_i == KIND_PWM && ev_o.uf && !mode_chg_i) |=> (alt_q != $past(alt_q))); // R3
    AST_ALT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (mode_chg_i || !run_q) |=> !alt_q); // R3
endmodule

// File: rtl/drt_datapath.sv
module drt_datapath #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dec_i,
    input  logic         uf_i,
    input  logic         rld_a_i,
    input  logic         rld_b_i,
    input  logic         cap_a_i,
    input  logic         cap_b_i,
    input  logic         toggle_en_i,
    input  logic [W-1:0] wdata_i,
    input  logic         we_timer_i,
    input  logic         we_a_i,
    input  logic         we_b_i,
    output logic [W-1:0] timer_o,
    output logic [W-1:0] reg_a_o,
    output logic [W-1:0] reg_b_o,
    output logic         ta_o,
    output logic         zero_o
);
    localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] timer_q, reg_a_q, reg_b_q;
    logic         ta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            reg_a_q <= '0;
            reg_b_q <= '0;
            ta_q    <= 1'b0;
        end else begin
            if (we_timer_i)   timer_q <= wdata_i;
            else if (rld_a_i) timer_q <= reg_a_q;
            else if (rld_b_i) timer_q <= reg_b_q;
            else if (dec_i)   timer_q <= timer_q - ONE_W;

            if (cap_a_i)     reg_a_q <= timer_q;
            else if (we_a_i) reg_a_q <= wdata_i;

            if (cap_b_i)     reg_b_q <= timer_q;
            else if (we_b_i) reg_b_q <= wdata_i;

            if (toggle_en_i && uf_i) ta_q <= ~ta_q;
        end
    end

    assign timer_o = timer_q;
    assign reg_a_o = reg_a_q;
    assign reg_b_o = reg_b_q;
    assign ta_o    = ta_q;
    assign zero_o  = (timer_q == '0);

    AST_RELOAD_FROM_A: assert property (@(posedge clk) disable iff (rst)
        (rld_a_i && !we_timer_i) |=> (timer_q == $past(reg_a_q))); // R3
    AST_RELOAD_FROM_B: assert property (@(posedge clk) disable iff (rst)
        (rld_b_i && !we_timer_i) |=> (timer_q == $past(reg_b_q))); // R3
    AST_TA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !toggle_en_i |=> $stable(ta_q)); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        we_timer_i |=> (timer_q == $past(wdata_i))); // R11
endmodule

// File: rtl/drt_flags.sv
module drt_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_a_i,
    input  logic set_b_i,
    input  logic clr_a_i,
    input  logic clr_b_i,
    input  logic en_a_i,
    input  logic en_b_i,
    input  logic cap_flag_i,
    output logic pend_a_o,
    output logic pend_b_o,
    output logic irq_o
);
    logic pend_a_q, pend_b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_a_q <= 1'b0;
            pend_b_q <= 1'b0;
        end else begin
            if (set_a_i)      pend_a_q <= 1'b1;
            else if (clr_a_i) pend_a_q <= 1'b0;
            if (set_b_i)      pend_b_q <= 1'b1;
            else if (clr_b_i) pend_b_q <= 1'b0;
        end
    end

    assign pend_a_o = pend_a_q;
    assign pend_b_o = pend_b_q;
    assign irq_o    = (pend_a_q & en_a_i) | (pend_b_q & en_b_i) | (cap_flag_i & en_a_i);

    AST_PEND_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend_a_q && !clr_a_i) |=> pend_a_q); // R6
    AST_PEND_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend_b_q && !clr_b_i) |=> pend_b_q); // R6
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        (set_a_i && clr_a_i) |=> pend_a_q); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (en_a_i || en_b_i)); // R5
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import drt_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic [2:0]   mode_i,
    input  logic [W-1:0] wdata_i,
    input  logic         we_timer_i,
    input  logic         we_a_i,
    input  logic         we_b_i,
    input  logic         run_set_i,
    input  logic         run_clr_i,
    input  logic         clr_pend_a_i,
    input  logic         clr_pend_b_i,
    input  logic         en_a_i,
    input  logic         en_b_i,
    input  logic         ta_i,
    input  logic         tb_i,
    output logic [W-1:0] timer_o,
    output logic [W-1:0] reg_a_o,
    output logic [W-1:0] reg_b_o,
    output logic         run_o,
    output logic         pend_a_o,
    output logic         pend_b_o,
    output logic         ta_o,
    output logic         ta_oe_o,
    output logic         irq_o
);
    localparam int NPINS = 2;

    mode_cfg_t  cfg;
    logic [2:0] mode_q;
    logic       mode_chg;
    logic [NPINS-1:0] pins;
    pin_edge_t  pin_e [NPINS];
    tmr_evt_t   ev;
    logic       zero;
    logic       set_a, set_b;

    assign cfg      = decode_mode(mode_i);
    assign mode_chg = (mode_i != mode_q);
    assign pins     = {tb_i, ta_i};

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_i;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        drt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .d_i   (pins[g]),
            .edg_o (pin_e[g])
        );
    end

    drt_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .kind_i       (cfg.kind),
        .evt_fall_i   (cfg.evt_fall),
        .cap_a_fall_i (cfg.cap_a_fall),
        .cap_b_fall_i (cfg.cap_b_fall),
        .mode_chg_i   (mode_chg),
        .tick_i       (tick_i),
        .ta_e_i       (pin_e[0]),
        .tb_e_i       (pin_e[1]),
        .timer_zero_i (zero),
        .run_set_i    (run_set_i),
        .run_clr_i    (run_clr_i),
        .ev_o         (ev),
        .run_o        (run_o)
    );

    drt_datapath #(.W(W)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .dec_i       (ev.dec),
        .uf_i        (ev.uf),
        .rld_a_i     (ev.rld_a),
        .rld_b_i     (ev.rld_b),
        .cap_a_i     (ev.cap_a),
        .cap_b_i     (ev.cap_b),
        .toggle_en_i (cfg.pwm_toggle),
        .wdata_i     (wdata_i),
        .we_timer_i  (we_timer_i),
        .we_a_i      (we_a_i),
        .we_b_i      (we_b_i),
        .timer_o     (timer_o),
        .reg_a_o     (reg_a_o),
        .reg_b_o     (reg_b_o),
        .ta_o        (ta_o),
        .zero_o      (zero)
    );

    assign set_a = ev.rld_a | ev.cap_a;
    assign set_b = ev.rld_b | ev.cap_b | ev.tb_evt;

    drt_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .set_a_i    (set_a),
        .set_b_i    (set_b),
        .clr_a_i    (clr_pend_a_i),
        .clr_b_i    (clr_pend_b_i),
        .en_a_i     (en_a_i),
        .en_b_i     (en_b_i),
        .cap_flag_i ((cfg.kind == KIND_CAP) & run_o),
        .pend_a_o   (pend_a_o),
        .pend_b_o   (pend_b_o),
        .irq_o      (irq_o)
    );

    assign ta_oe_o = cfg.pwm_toggle;

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg.kind == KIND_PWM && !run_o && !we_timer_i) |=> $stable(timer_o)); // R2
    AST_EVT_NO_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg.kind == KIND_EVT && !pin_e[0].rise && !pin_e[0].fall && !we_timer_i) |=> $stable(timer_o)); // R7
    AST_CAP_UF_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cfg.kind == KIND_CAP && ev.uf) |=> run_o); // R10
    AST_CAP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cfg.kind == KIND_CAP && ev.uf && !we_timer_i) |=> (timer_o == {W{1'b1}})); // R9
endmodule

// File: tb/dual_reload_timer_bench.sv
`timescale 1ns/1ps
module dual_reload_timer_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, tick, we_timer, we_a, we_b, run_set, run_clr, clr_a, clr_b, en_a, en_b, ta_in, tb_in;
    logic [2:0]   mode;
    logic [W-1:0] wdata;
    logic [W-1:0] timer_o, reg_a_o, reg_b_o;
    logic         run_o, pend_a_o, pend_b_o, ta_o, ta_oe_o, irq_o;

    dual_reload_timer u_dual_reload_timer (
        .clk(clk), .rst(rst), .tick_i(tick), .mode_i(mode), .wdata_i(wdata),
        .we_timer_i(we_timer), .we_a_i(we_a), .we_b_i(we_b),
        .run_set_i(run_set), .run_clr_i(run_clr),
        .clr_pend_a_i(clr_a), .clr_pend_b_i(clr_b), .en_a_i(en_a), .en_b_i(en_b),
        .ta_i(ta_in), .tb_i(tb_in),
        .timer_o(timer_o), .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .run_o(run_o),
        .pend_a_o(pend_a_o), .pend_b_o(pend_b_o), .ta_o(ta_o), .ta_oe_o(ta_oe_o), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int sel, input logic [W-1:0] d);
        wdata = d; we_timer = (sel == 0); we_a = (sel == 1); we_b = (sel == 2);
        cyc(1);
        we_timer = 1'b0; we_a = 1'b0; we_b = 1'b0;
    endtask

    task automatic run_pulse(input bit set);
        run_set = set; run_clr = !set;
        cyc(1);
        run_set = 1'b0; run_clr = 1'b0;
    endtask

    task automatic clr_pend(input bit a, input bit b);
        clr_a = a; clr_b = b;
        cyc(1);
        clr_a = 1'b0; clr_b = 1'b0;
    endtask

    task automatic pin_ta(input logic v);
        ta_in = v;
        cyc(3);
    endtask

    function automatic logic irq_model(input logic pa, input logic pb, input logic ea, input logic eb);
        return (pa & ea) | (pb & eb);
    endfunction

    // Bench model state for the waveform mode
    logic [W-1:0] m_tm, m_a, m_b;
    logic m_alt, m_run, m_ta, m_pa, m_pb;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic save_ta;
        void'($urandom(32'd20240611));
        rst = 1; tick = 0; mode = 3'b000; wdata = '0; we_timer = 0; we_a = 0; we_b = 0;
        run_set = 0; run_clr = 0; clr_a = 0; clr_b = 0; en_a = 0; en_b = 0; ta_in = 0; tb_in = 0;
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        chk("R1", "timer", timer_o, 0);
        chk("R1", "reg_a", reg_a_o, 0);
        chk("R1", "reg_b", reg_b_o, 0);
        chk("R1", "pend", {pend_a_o, pend_b_o}, 0);
        chk("R1", "run", run_o, 0);
        chk("R1", "ta_o", ta_o, 0);
        chk("R1", "irq", irq_o, 0);

        // Waveform mode: random rounds against the bench model (R2 R3 R4 R5 R6)
        mode = 3'b001;
        cyc(1);
        m_ta = 1'b0;
        for (int round = 0; round < 3; round++) begin
            run_pulse(0);
            clr_pend(1, 1);
            m_a = W'($urandom % 6); m_b = W'($urandom % 6); m_tm = W'($urandom % 6);
            wr(1, m_a); wr(2, m_b); wr(0, m_tm);
            m_alt = 0; m_run = 0; m_pa = 0; m_pb = 0;
            for (int i = 0; i < 300; i++) begin
                logic uf, sa, sb;
                chk("R2", "timer", timer_o, m_tm);
                chk("R2", "run", run_o, m_run);
                chk("R6", "pend_a", pend_a_o, m_pa);
                chk("R6", "pend_b", pend_b_o, m_pb);
                chk("R5", "irq", irq_o, irq_model(m_pa, m_pb, en_a, en_b));
                chk("R4", "ta_o", ta_o, m_ta);
                chk("R4", "ta_oe", ta_oe_o, 1);
                tick    = (i < 40) ? 1'b1 : 1'($urandom % 2);
                run_set = (i == 0) || ($urandom % 40 == 0);
                run_clr = (i > 40) && ($urandom % 30 == 0);
                clr_a   = ($urandom % 6 == 0);
                clr_b   = ($urandom % 6 == 0);
                if ($urandom % 20 == 0) en_a = 1'($urandom % 2);
                if ($urandom % 20 == 0) en_b = 1'($urandom % 2);
                uf = m_run && tick && (m_tm == 0);
                sa = 0; sb = 0;
                if (m_run && tick) begin
                    if (m_tm == 0) begin
                        if (m_alt) begin m_tm = m_b; sb = 1; end
                        else begin m_tm = m_a; sa = 1; end
                        m_ta = ~m_ta;
                    end else begin
                        m_tm = m_tm - 1'b1;
                    end
                end
                if (!m_run) m_alt = 0;
                else if (uf) m_alt = ~m_alt;
                m_pa = sa ? 1'b1 : (clr_a ? 1'b0 : m_pa);
                m_pb = sb ? 1'b1 : (clr_b ? 1'b0 : m_pb);
                m_run = run_set ? 1'b1 : (run_clr ? 1'b0 : m_run);
                cyc(1);
            end
            chk("R3", "timer end", timer_o, m_tm);
            tick = 0; run_set = 0; run_clr = 0; clr_a = 0; clr_b = 0;
        end

        // R3: first reload from A, alternation restarts after a mode change
        run_pulse(0);
        wr(1, 16'd2); wr(2, 16'd5); wr(0, 16'd0);
        clr_pend(1, 1);
        run_pulse(1);
        tick = 1; cyc(1); tick = 0;
        chk("R3", "first reload from A", timer_o, 2);
        chk("R5", "pend_a after A reload", pend_a_o, 1);
        mode = 3'b000; cyc(1);
        chk("R4", "ta_oe in 000", ta_oe_o, 0);
        mode = 3'b001; cyc(1);
        tick = 1; cyc(3); tick = 0;
        chk("R3", "reload from A after mode change", timer_o, 2);

        // R4: mode 000 keeps TA level on underflow
        mode = 3'b000; cyc(1);
        save_ta = ta_o;
        tick = 1; cyc(3); tick = 0;
        chk("R4", "ta_o held in 000", ta_o, save_ta);
        chk("R3", "reload in 000", timer_o, 2);

        // R6: set and clear in the same cycle
        mode = 3'b001; cyc(1);
        wr(0, 16'd0);
        clr_pend(1, 1);
        tick = 1; clr_a = 1; cyc(1); tick = 0; clr_a = 0;
        chk("R6", "set beats clear", pend_a_o, 1);
        clr_pend(1, 0);
        chk("R6", "clear alone", pend_a_o, 0);

        // R7: event counting on TA
        run_pulse(0);
        mode = 3'b010;
        wr(1, 16'd5); wr(0, 16'd2);
        clr_pend(1, 1);
        run_pulse(1);
        tick = 1;
        pin_ta(1);
        chk("R7", "rising edge counts", timer_o, 1);
        pin_ta(0);
        chk("R7", "falling edge ignored", timer_o, 1);
        pin_ta(1);
        chk("R7", "count to zero", timer_o, 0);
        pin_ta(0);
        pin_ta(1);
        chk("R7", "underflow reloads A", timer_o, 5);
        chk("R7", "underflow sets pend_a", pend_a_o, 1);
        chk("R7", "ta_oe low", ta_oe_o, 0);
        mode = 3'b011;
        clr_pend(1, 0);
        pin_ta(0);
        chk("R7", "falling select counts", timer_o, 4);
        pin_ta(1);
        chk("R7", "rising ignored when falling selected", timer_o, 4);

        // R8: TB rising edge in event mode
        chk("R8", "pend_b before TB", pend_b_o, 0);
        tb_in = 1; cyc(3);
        chk("R8", "TB rise sets pend_b", pend_b_o, 1);
        tb_in = 0; cyc(3);
        chk("R8", "pend_b sticky", pend_b_o, 1);
        tick = 0;

        // R9: capture on TA and TB with selectable polarity
        mode = 3'b100;
        clr_pend(1, 1);
        wr(0, 16'h1234);
        pin_ta(0);
        chk("R9", "wrong TA polarity ignored", reg_a_o, 5);
        pin_ta(1);
        chk("R9", "TA capture", reg_a_o, 16'h1234);
        chk("R9", "TA capture pend_a", pend_a_o, 1);
        mode = 3'b110;
        tb_in = 1; cyc(3);
        chk("R9", "wrong TB polarity ignored", reg_b_o, 5);
        wr(0, 16'h0BCD);
        tb_in = 0; cyc(3);
        chk("R9", "TB falling capture", reg_b_o, 16'h0BCD);
        chk("R9", "TB capture pend_b", pend_b_o, 1);

        // R10: capture underflow uses the run bit
        clr_pend(1, 1);
        run_pulse(0);
        chk("R10", "run cleared", run_o, 0);
        en_a = 1; en_b = 0;
        wr(0, 16'd1);
        tick = 1; cyc(1);
        chk("R9", "counts without run", timer_o, 0);
        cyc(1);
        tick = 0;
        chk("R9", "wrap to all ones", timer_o, 16'hFFFF);
        chk("R10", "underflow sets run", run_o, 1);
        chk("R10", "irq from run flag", irq_o, 1);
        run_pulse(0);
        chk("R10", "run flag cleared", run_o, 0);
        chk("R10", "irq gone", irq_o, 0);

        // R11: write beats decrement
        tick = 1; wdata = 16'd7; we_timer = 1; cyc(1);
        we_timer = 0; tick = 0;
        chk("R11", "write beats tick", timer_o, 7);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule